// File: doc/BRIEF.md
# Boot Handshake Control Registers

This block is a small memory-mapped register file on a 32-bit register port. It occupies one 4 KiB window. A boot program and an external loader use it to agree on when and where the main program starts. A group of scratch words holds a 64-bit program entry address, split into a low word and a high word. The third scratch word carries a start flag, which drives a launch signal toward the controller that releases the cores. When the program ends, that same word holds its return code. Any remaining scratch words are free for software use.

Software can also read four words that it cannot write:

- the live value of the two boot-mode pins;
- a flags word that reports which peripherals were built into the chip;
- the real-time clock frequency;
- the platform ROM address.

The last three are fixed by parameters.

Each request is held for one cycle with `reqValid` high. It receives exactly one response in the following cycle: `rspReady`, together with read data and an error flag.

Top module: `bootctl_regs`

## Requirements
- R1: After reset, every scratch word reads 0, `launch` is low, and `rspReady` and `rspError` are low.
- R2: Scratch word i is at byte offset 4*i, for i < NumScratch. Each one stores a full 32-bit write and reads it back. Offset 0x000 holds the low half of the entry address and offset 0x004 holds the high half.
- R3: `launch` always equals bit 0 of scratch word 2, at offset 0x008. A write to that offset changes `launch` in the cycle after the request.
- R4: A write to offset 0x008 stores all 32 bits unchanged, so a return code in bits 31:1 with bit 0 set reads back as written.
- R5: Offset 0x040 reads the current `bootMode` pins in bits 1:0. The other bits read 0.
- R6: Offset 0x044 reads the peripheral flags. Bit 2 is UART, bit 3 is SPI host, bit 4 is I2C, bit 5 is GPIO, bit 6 is DMA, bit 7 is serial link and bit 8 is VGA. They are taken from `PeriphMask` bits 0 to 6 in that order. All other bits read 0.
- R7: Offset 0x048 reads the `RtcHz` parameter and offset 0x04C reads the `RomBase` parameter.
- R8: A write to any of offsets 0x040 to 0x04C has no effect and responds without error.
- R9: Three kinds of access respond with `rspError` set and read data 0, and a write of any of these kinds changes no register:
  - a misaligned address (bits 1:0 not zero);
  - a scratch index at or above NumScratch, below offset 0x040;
  - any offset above 0x04C.
- R10: Each request gets exactly one response, with `rspReady` high for one cycle in the cycle after the request. When no request is made, `rspReady` stays low. Back-to-back requests are answered back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AddrW | Byte offset inside the window |
| reqWdata | input | 32 | Write data |
| rspReady | output | 1 | Response valid (one cycle after request) |
| rspRdata | output | 32 | Read data, 0 on writes and errors |
| rspError | output | 1 | Request decoded to no register |
| bootMode | input | 2 | Boot source selection pins |
| launch | output | 1 | Start request to the core-release controller |

## Verification
The bench builds the block with six scratch words, not the default four. This places the first unmapped scratch index at 0x018, below the read-only group, so that index can be probed. It also uses a peripheral mask of 7'b0110101, which differs from the default, so each flag bit position is checked against a value that is not the default. The ROM address and clock frequency are also non-default, so the parameter words cannot match by accident. Back-to-back requests exercise the one-cycle response pipeline.

// File: rtl/bootctl_pkg.sv
package bootctl_pkg;
  localparam int DataW       = 32;
  localparam int MaxScratch  = 16;
  localparam int IdxW        = $clog2(MaxScratch);
  localparam int OffBootMode = 'h040;
  localparam int OffCaps     = 'h044;
  localparam int OffRtc      = 'h048;
  localparam int OffRom      = 'h04C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SCRATCH, SEL_MODE, SEL_CAPS, SEL_RTC, SEL_ROM
  } sel_e;

  typedef struct packed {
    logic            valid;
    logic            rd;
    logic            we;
    logic            err;
    sel_e            sel;
    logic [IdxW-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/bootctl_ctrl.sv
module bootctl_ctrl
  import bootctl_pkg::*;
#(
  parameter int AddrW      = 12,
  parameter int NumScratch = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [AddrW-1:0] reqAddr,
  output strobe_t          stb,
  output logic             rspReady,
  output logic             rspError
);
  logic aligned;
  logic inScratch;

  assign aligned   = (reqAddr[1:0] == 2'b00);
  assign inScratch = (reqAddr[AddrW-1:IdxW+2] == '0);

  always_comb begin
    stb       = '0;
    stb.sel   = SEL_NONE;
    stb.idx   = reqAddr[IdxW+1:2];
    stb.valid = reqValid;
    if (reqValid) begin
      if (!aligned) begin
        stb.err = 1'b1;
      end else if (inScratch) begin
        if (int'(stb.idx) < NumScratch) begin
          stb.sel = SEL_SCRATCH;
          stb.we  = reqWrite;
        end else begin
          stb.err = 1'b1;
        end
      end else if (reqAddr == AddrW'(OffBootMode)) begin
        stb.sel = SEL_MODE;
      end else if (reqAddr == AddrW'(OffCaps)) begin
        stb.sel = SEL_CAPS;
      end else if (reqAddr == AddrW'(OffRtc)) begin
        stb.sel = SEL_RTC;
      end else if (reqAddr == AddrW'(OffRom)) begin
        stb.sel = SEL_ROM;
      end else begin
        stb.err = 1'b1;
      end
      stb.rd = !reqWrite && !stb.err;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspReady <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspReady <= stb.valid;
      rspError <= stb.valid && stb.err;
    end
  end
endmodule

// File: rtl/bootctl_data.sv
module bootctl_data
  import bootctl_pkg::*;
#(
  parameter int          NumScratch = 4,
  parameter logic [6:0]  PeriphMask = 7'b1111111,
  parameter logic [31:0] RtcHz      = 32'd32768,
  parameter logic [31:0] RomBase    = 32'h0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [DataW-1:0] wdata,
  input  logic [1:0]       bootMode,
  output logic [DataW-1:0] rdata,
  output logic             launch
);
  localparam logic [DataW-1:0] CapsWord = DataW'(PeriphMask) << 2;
  localparam int               LaunchIdx = 2;

  logic [DataW-1:0] scratch [NumScratch];
  logic [DataW-1:0] rdNext;

  for (genvar i = 0; i < NumScratch; i++) begin : g_scr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        scratch[i] <= '0;
      end else if (stb.we && stb.idx == IdxW'(i)) begin
        scratch[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (stb.sel)
      SEL_SCRATCH: begin
        for (int i = 0; i < NumScratch; i++) begin
          if (stb.idx == IdxW'(i)) rdNext = scratch[i];
        end
      end
      SEL_MODE: rdNext = {{(DataW-2){1'b0}}, bootMode};
      SEL_CAPS: rdNext = CapsWord;
      SEL_RTC:  rdNext = RtcHz;
      SEL_ROM:  rdNext = RomBase;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (stb.valid) rdata <= stb.rd ? rdNext : '0;
  end

  assign launch = scratch[LaunchIdx][0];
endmodule

// File: rtl/bootctl_regs.sv
module bootctl_regs
  import bootctl_pkg::*;
#(
  parameter int          WinBytes   = 4096,
  parameter int          AddrW      = $clog2(WinBytes),
  parameter int          NumScratch = 4,
  parameter logic [6:0]  PeriphMask = 7'b1111111,
  parameter logic [31:0] RtcHz      = 32'd32768,
  parameter logic [31:0] RomBase    = 32'h0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [31:0]      reqWdata,
  output logic             rspReady,
  output logic [31:0]      rspRdata,
  output logic             rspError,
  input  logic [1:0]       bootMode,
  output logic             launch
);
  strobe_t stb;

  bootctl_ctrl #(.AddrW(AddrW), .NumScratch(NumScratch)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .stb(stb), .rspReady(rspReady), .rspError(rspError)
  );

  bootctl_data #(.NumScratch(NumScratch), .PeriphMask(PeriphMask),
                 .RtcHz(RtcHz), .RomBase(RomBase)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(reqWdata),
    .bootMode(bootMode), .rdata(rspRdata), .launch(launch)
  );
endmodule

// File: rtl/bootctl_regs_chk.sv
module bootctl_regs_chk #(
  parameter int AddrW = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqWrite,
  input logic [AddrW-1:0] reqAddr,
  input logic [31:0]      reqWdata,
  input logic             rspReady,
  input logic [31:0]      rspRdata,
  input logic             rspError,
  input logic             launch
);
  logic wrLaunch;
  logic wrRo;
  assign wrLaunch = reqValid && reqWrite && reqAddr == AddrW'('h008);
  assign wrRo     = reqValid && reqWrite && reqAddr[AddrW-1:4] == (AddrW-4)'('h04);

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!launch && !rspReady && !rspError);
    end
  end

  p_launch_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrLaunch && reqWdata[0] |=> launch);
  p_launch_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrLaunch && !reqWdata[0] |=> !launch);
  p_launch_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrLaunch |=> $stable(launch));
  p_ro_write_ok_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrRo && reqAddr[1:0] == 2'b00 |=> !rspError);
  p_misalign_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAddr[1:0] != 2'b00 |=> rspError);
  p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspRdata == 32'h0 && rspReady);
  p_resp_next_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspReady);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspReady);
endmodule

bind bootctl_regs bootctl_regs_chk #(.AddrW(AddrW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady),
  .rspRdata(rspRdata), .rspError(rspError), .launch(launch)
);

// File: tb/bootctl_regs_test.sv
module bootctl_regs_test;
  localparam int          AddrW   = 12;
  localparam int          NScr    = 6;
  localparam logic [6:0]  Mask    = 7'b0110101;
  localparam logic [31:0] Rtc     = 32'd1_000_000;
  localparam logic [31:0] Rom     = 32'h1234_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AddrW-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic rspReady, rspError, launch;
  logic [31:0] rspRdata;
  logic [1:0] bootMode = 2'b00;

  int checks = 0, fails = 0, pushed = 0, popped = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        chkData;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  bootctl_regs #(.NumScratch(NScr), .PeriphMask(Mask), .RtcHz(Rtc),
                 .RomBase(Rom)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady),
    .rspRdata(rspRdata), .rspError(rspError), .bootMode(bootMode),
    .launch(launch)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue expectation, drive one cycle
  task automatic issue(input bit wr, input int addr, input logic [31:0] wd,
                       input logic [31:0] expD, input bit expE, input string tag);
    exp_t e;
    e.data = expD; e.err = expE; e.chkData = !wr; e.tag = tag;
    expQ.push_back(e);
    pushed++;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AddrW'(addr); reqWdata = wd;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic acc(input bit wr, input int addr, input logic [31:0] wd,
                     input logic [31:0] expD, input bit expE, input string tag);
    issue(wr, addr, wd, expD, expE, tag);
    idle();
    @(negedge clk);
  endtask

  // monitor: compare responses as they appear
  always @(negedge clk) begin
    if (rstN && rspReady) begin
      exp_t e;
      popped++;
      if (expQ.size() == 0) begin
        check(0, "R10 unexpected response", 32'd1, 32'd0);
      end else begin
        e = expQ.pop_front();
        check(rspError == e.err, {e.tag, " error flag"}, 32'(rspError), 32'(e.err));
        if (e.chkData || e.err)
          check(rspRdata == e.data, {e.tag, " data"}, rspRdata, e.data);
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] caps;
    caps = '0;
    for (int b = 0; b < 7; b++) caps[b+2] = Mask[b];

    repeat (3) @(negedge clk);
    check(!launch && !rspReady && !rspError, "R1 reset outputs", 32'(launch), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!rspReady, "R1 no response after reset", 32'(rspReady), 32'd0);
    for (int i = 0; i < NScr; i++) acc(0, 4*i, 0, 32'h0, 0, "R1 scratch reset");

    acc(1, 'h000, 32'h8000_1000, 0, 0, "R2 write entry low");
    acc(1, 'h004, 32'h0000_0001, 0, 0, "R2 write entry high");
    acc(1, 'h014, 32'hDEAD_BEEF, 0, 0, "R2 write last scratch");
    acc(0, 'h000, 0, 32'h8000_1000, 0, "R2 entry low readback");
    acc(0, 'h004, 0, 32'h0000_0001, 0, "R2 entry high readback");
    acc(0, 'h014, 0, 32'hDEAD_BEEF, 0, "R2 last scratch readback");
    check(!launch, "R3 launch low before start", 32'(launch), 32'd0);

    issue(1, 'h008, 32'h1, 0, 0, "R3 start write");
    @(negedge clk);
    reqValid = 1'b0;
    check(launch, "R3 launch next cycle", 32'(launch), 32'd1);
    @(negedge clk);
    acc(0, 'h008, 0, 32'h1, 0, "R3 start flag readback");

    acc(1, 'h008, 32'h0000_002B, 0, 0, "R4 return code write");
    acc(0, 'h008, 0, 32'h0000_002B, 0, "R4 return code readback");
    check(launch, "R4 launch held with code", 32'(launch), 32'd1);
    acc(1, 'h008, 32'hFFFF_FFFE, 0, 0, "R3 clear flag");
    check(!launch, "R3 launch drops", 32'(launch), 32'd0);
    acc(0, 'h008, 0, 32'hFFFF_FFFE, 0, "R4 high bits kept");

    bootMode = 2'b10;
    acc(0, 'h040, 0, 32'h2, 0, "R5 boot mode 2");
    bootMode = 2'b01;
    acc(0, 'h040, 0, 32'h1, 0, "R5 boot mode 1");
    bootMode = 2'b11;
    acc(0, 'h040, 0, 32'h3, 0, "R5 boot mode 3");

    acc(0, 'h044, 0, caps, 0, "R6 capability flags");
    acc(0, 'h048, 0, Rtc, 0, "R7 rtc frequency");
    acc(0, 'h04C, 0, Rom, 0, "R7 rom address");

    acc(1, 'h044, 32'hFFFF_FFFF, 0, 0, "R8 write caps");
    acc(1, 'h048, 32'h0, 0, 0, "R8 write rtc");
    acc(1, 'h040, 32'h0, 0, 0, "R8 write mode");
    acc(0, 'h044, 0, caps, 0, "R8 caps unchanged");
    acc(0, 'h048, 0, Rtc, 0, "R8 rtc unchanged");
    acc(0, 'h040, 0, 32'h3, 0, "R8 mode unchanged");

    acc(0, 'h018, 0, 32'h0, 1, "R9 scratch index past end");
    acc(1, 'h018, 32'h5555_5555, 0, 1, "R9 write past end");
    acc(0, 'h050, 0, 32'h0, 1, "R9 above read-only group");
    acc(0, 'hFFC, 0, 32'h0, 1, "R9 top of window");
    acc(1, 'h002, 32'h1234_5678, 0, 1, "R9 misaligned write");
    acc(1, 'h00A, 32'h0000_0001, 0, 1, "R9 misaligned near start flag");
    check(!launch, "R9 misaligned write leaves launch", 32'(launch), 32'd0);
    acc(0, 'h000, 0, 32'h8000_1000, 0, "R9 scratch0 untouched");

    issue(0, 'h000, 0, 32'h8000_1000, 0, "R10 burst first");
    issue(0, 'h004, 0, 32'h0000_0001, 0, "R10 burst second");
    issue(0, 'h044, 0, caps, 0, "R10 burst third");
    idle();
    repeat (3) @(negedge clk);
    check(pushed == popped && expQ.size() == 0, "R10 one response per request",
          32'(popped), 32'(pushed));
    check(!rspReady, "R10 ready idle", 32'(rspReady), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule